// File: doc/BRIEF.md
# Randomized Clock Cycle Skipper

This block produces the clock-enable stream for a cipher engine that sits behind an integrated clock gate. Two candidate clock sources, a phase-locked loop and a free-running oscillator, appear inside the block's single clock domain as one-cycle tick strobes. The block picks one of them, divides its ticks down by a programmable ratio, and then, in every window of a programmable number of divided cycles, removes exactly one divided cycle. Which cycle goes is chosen by a linear feedback shift register, so the engine's activity pattern shifts from window to window and power or emission traces are harder to line up.

The random position is the register value reduced modulo the window length, compared against a counter that walks through the window. At each window end the counter clears and the register steps once. Outside logic can reload the register at any time from a true random source. A reload also restarts the divider and the window, so that the stream after a reseed is fully defined by the new seed and the configuration. Randomization can be switched off, and then every divided cycle reaches the engine.

Top module: `rand_clk_skipper`

## Requirements
- R1: While reset is asserted, and afterwards until a divided cycle occurs, `eng_clk_en` is low.
- R2: With `src_sel` = 0 only `pll_tick` is counted, and with `src_sel` = 1 only `osc_tick` is counted; ticks on the source not selected never produce an enable.
- R3: With divide ratio N (a value of 0 acts as 1), every Nth selected tick after a reseed or reset is a divided cycle; the enable for a divided cycle (if not skipped) is high in the clock cycle that follows the tick, and only then.
- R4: The window length is `win_len` divided cycles, with values 0 and 1 acting as 2; divided cycles are numbered 0 to length-1 within a window, and the numbering restarts after the last one.
- R5: With randomization on, in each complete window exactly one divided cycle is suppressed, the one whose number equals the current target, so a window yields length-1 enables.
- R6: The 16-bit register steps as next = {cur[14:0], cur[15]^cur[13]^cur[12]^cur[10]} once at the end of every window, and the target for the next window is the stepped value modulo the window length.
- R7: A `seed_valid` cycle loads the register with `seed`, sets the target to that value modulo the window length, restarts the divider and the window at number 0, and yields no enable in the following cycle.
- R8: A seed of zero loads 16'hACE1 instead, so the register never holds zero.
- R9: With `rand_en` low no divided cycle is suppressed, while the register still steps at each window end, so switching randomization on later continues the same sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; all source ticks are strobes in this domain |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_sel | input | 1 | Source choice: 0 takes the PLL ticks, 1 the oscillator ticks |
| pll_tick | input | 1 | One-cycle strobe per PLL clock cycle |
| osc_tick | input | 1 | One-cycle strobe per oscillator clock cycle |
| div_ratio | input | 8 | Division ratio of the selected source (0 acts as 1) |
| win_len | input | 8 | Window length in divided cycles (0 and 1 act as 2) |
| rand_en | input | 1 | Enables suppression of one divided cycle per window |
| seed_valid | input | 1 | Loads `seed` and restarts divider and window |
| seed | input | 16 | Reseed value from an external entropy source |
| eng_clk_en | output | 1 | Enable for the engine's clock gate, registered |

## Verification
The bench predicts every skip position from the seed and the stepping rule, so a design that reduced the random value against the wrong length, stepped the register at the wrong moment or compared against the counter off by one would suppress a different cycle and miscompare on that cycle. Windows with the smallest legal length, ratio and length values of zero, and a long 37-cycle window go after the clamping and the wrap, where a wrong boundary skips nothing or skips twice. The unselected source keeps ticking throughout, so a swapped source mux yields enables in idle gaps, and a zero seed checks that the fallback value is used instead of a register stuck at zero. Turning randomization on mid-stream without a reseed exposes a design that froze the register while suppression was off.

// File: rtl/rcs_pkg.sv
package rcs_pkg;

    // Which clock source feeds the divider
    typedef enum logic {
        SRC_PLL = 1'b0,
        SRC_OSC = 1'b1
    } src_e;

    localparam int unsigned DEF_LFSR_W = 16;
    localparam int unsigned DEF_DIV_W  = 8;
    localparam int unsigned DEF_WIN_W  = 8;

    // Feedback taps at bits 15, 13, 12 and 10 of the 16-bit register
    localparam logic [DEF_LFSR_W-1:0] DEF_TAPS     = 16'hB400;
    // Replacement for an all-zero seed
    localparam logic [DEF_LFSR_W-1:0] DEF_FALLBACK = 16'hACE1;

endpackage

// File: rtl/rcs_src_div.sv
module rcs_src_div
    import rcs_pkg::*;
#(
    parameter int unsigned DIV_W = DEF_DIV_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  src_e             src_sel,
    input  logic             pll_tick,
    input  logic             osc_tick,
    input  logic [DIV_W-1:0] ratio,
    input  logic             restart,
    output logic             sel_tick,
    output logic             div_hit
);

    localparam logic [DIV_W-1:0] ONE = DIV_W'(1);

    typedef struct packed {
        logic [DIV_W-1:0] cnt;
    } div_st_t;

    div_st_t          st_d, st_q;
    logic [DIV_W-1:0] ratio_eff;

    always_comb begin
        st_d      = st_q;
        div_hit   = 1'b0;
        sel_tick  = (src_sel == SRC_OSC) ? osc_tick : pll_tick;
        ratio_eff = (ratio == '0) ? ONE : ratio;

        if (restart) begin
            st_d.cnt = '0;
        end else if (sel_tick) begin
            // >= keeps the divider sane when the ratio shrinks mid-count
            if (st_q.cnt >= ratio_eff - ONE) begin
                div_hit  = 1'b1;
                st_d.cnt = '0;
            end else begin
                st_d.cnt = st_q.cnt + ONE;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/rcs_skip_window.sv
module rcs_skip_window
    import rcs_pkg::*;
#(
    parameter int unsigned              LFSR_W   = DEF_LFSR_W,
    parameter int unsigned              WIN_W    = DEF_WIN_W,
    parameter logic [LFSR_W-1:0]        TAPS     = DEF_TAPS,
    parameter logic [LFSR_W-1:0]        FALLBACK = DEF_FALLBACK
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              div_hit,
    input  logic              rand_en,
    input  logic [WIN_W-1:0]  win_len,
    input  logic              seed_load,
    input  logic [LFSR_W-1:0] seed,
    output logic              en,
    output logic [LFSR_W-1:0] lfsr_o
);

    localparam logic [WIN_W-1:0] ONE     = WIN_W'(1);
    localparam logic [WIN_W-1:0] MIN_WIN = WIN_W'(2);

    typedef struct packed {
        logic [WIN_W-1:0]  win_cnt;
        logic [WIN_W-1:0]  tgt;
        logic [LFSR_W-1:0] lfsr;
        logic              en;
    } win_st_t;

    win_st_t           st_d, st_q;
    logic [WIN_W-1:0]  win_eff;
    logic [LFSR_W-1:0] seed_eff;
    logic [LFSR_W-1:0] lfsr_nxt;
    logic              skip;
    logic              wrap;

    function automatic logic [LFSR_W-1:0] lfsr_step(input logic [LFSR_W-1:0] v);
        return {v[LFSR_W-2:0], ^(v & TAPS)};
    endfunction

    function automatic logic [WIN_W-1:0] reduce(input logic [LFSR_W-1:0] v,
                                                input logic [WIN_W-1:0]  w);
        logic [LFSR_W-1:0] rem;
        rem = v % LFSR_W'(w);
        return rem[WIN_W-1:0];
    endfunction

    always_comb begin
        st_d     = st_q;
        st_d.en  = 1'b0;
        skip     = 1'b0;
        wrap     = 1'b0;
        win_eff  = (win_len < MIN_WIN) ? MIN_WIN : win_len;
        seed_eff = (seed == '0) ? FALLBACK : seed;
        lfsr_nxt = lfsr_step(st_q.lfsr);

        if (seed_load) begin
            st_d.lfsr    = seed_eff;
            st_d.tgt     = reduce(seed_eff, win_eff);
            st_d.win_cnt = '0;
        end else if (div_hit) begin
            skip    = rand_en && (st_q.win_cnt == st_q.tgt);
            wrap    = (st_q.win_cnt >= win_eff - ONE);
            st_d.en = !skip;
            if (wrap) begin
                st_d.win_cnt = '0;
                st_d.lfsr    = lfsr_nxt;
                st_d.tgt     = reduce(lfsr_nxt, win_eff);
            end else begin
                st_d.win_cnt = st_q.win_cnt + ONE;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.win_cnt <= '0;
            st_q.tgt     <= '0;
            st_q.lfsr    <= FALLBACK;
            st_q.en      <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign en     = st_q.en;
    assign lfsr_o = st_q.lfsr;

endmodule

// File: rtl/rand_clk_skipper.sv
module rand_clk_skipper
    import rcs_pkg::*;
#(
    parameter int unsigned       LFSR_W        = DEF_LFSR_W,
    parameter int unsigned       DIV_W         = DEF_DIV_W,
    parameter int unsigned       WIN_W         = DEF_WIN_W,
    parameter logic [LFSR_W-1:0] LFSR_TAPS     = DEF_TAPS,
    parameter logic [LFSR_W-1:0] SEED_FALLBACK = DEF_FALLBACK
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              src_sel,
    input  logic              pll_tick,
    input  logic              osc_tick,
    input  logic [DIV_W-1:0]  div_ratio,
    input  logic [WIN_W-1:0]  win_len,
    input  logic              rand_en,
    input  logic              seed_valid,
    input  logic [LFSR_W-1:0] seed,
    output logic              eng_clk_en
);

    src_e              sel_e;
    logic              sel_tick;
    logic              div_hit;
    logic [LFSR_W-1:0] lfsr_cur;

    assign sel_e = src_e'(src_sel);

    rcs_src_div #(
        .DIV_W (DIV_W)
    ) u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .src_sel  (sel_e),
        .pll_tick (pll_tick),
        .osc_tick (osc_tick),
        .ratio    (div_ratio),
        .restart  (seed_valid),
        .sel_tick (sel_tick),
        .div_hit  (div_hit)
    );

    rcs_skip_window #(
        .LFSR_W   (LFSR_W),
        .WIN_W    (WIN_W),
        .TAPS     (LFSR_TAPS),
        .FALLBACK (SEED_FALLBACK)
    ) u_win (
        .clk       (clk),
        .rst_n     (rst_n),
        .div_hit   (div_hit),
        .rand_en   (rand_en),
        .win_len   (win_len),
        .seed_load (seed_valid),
        .seed      (seed),
        .en        (eng_clk_en),
        .lfsr_o    (lfsr_cur)
    );

endmodule

// File: rtl/rcs_chk.sv
module rcs_chk #(
    parameter int unsigned       LFSR_W   = 16,
    parameter int unsigned       DIV_W    = 8,
    parameter logic [LFSR_W-1:0] FALLBACK = 16'hACE1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              src_sel,
    input logic              pll_tick,
    input logic              osc_tick,
    input logic [DIV_W-1:0]  div_ratio,
    input logic              rand_en,
    input logic              seed_valid,
    input logic [LFSR_W-1:0] seed,
    input logic              eng_clk_en,
    input logic [LFSR_W-1:0] lfsr_cur
);

    logic chosen_tick;
    assign chosen_tick = src_sel ? osc_tick : pll_tick;

    AST_EN_NEEDS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        eng_clk_en |-> $past(chosen_tick) && !$past(seed_valid)); // R3

    AST_RESEED_BLANKS: assert property (@(posedge clk) disable iff (!rst_n)
        seed_valid |=> !eng_clk_en); // R7

    AST_PASS_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (!rand_en && div_ratio <= DIV_W'(1) && chosen_tick && !seed_valid) |=> eng_clk_en); // R9

    AST_ZERO_SEED_SUBST: assert property (@(posedge clk) disable iff (!rst_n)
        (seed_valid && seed == '0) |=> lfsr_cur == FALLBACK); // R8

    AST_LFSR_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        lfsr_cur != '0); // R8

endmodule

bind rand_clk_skipper rcs_chk #(
    .LFSR_W   (LFSR_W),
    .DIV_W    (DIV_W),
    .FALLBACK (SEED_FALLBACK)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .src_sel    (src_sel),
    .pll_tick   (pll_tick),
    .osc_tick   (osc_tick),
    .div_ratio  (div_ratio),
    .rand_en    (rand_en),
    .seed_valid (seed_valid),
    .seed       (seed),
    .eng_clk_en (eng_clk_en),
    .lfsr_cur   (lfsr_cur)
);

// File: tb/sim_rand_clk_skipper.sv
`timescale 1ns/1ps
module sim_rand_clk_skipper;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        src_sel = 1'b0;
    logic        pll_tick = 1'b0;
    logic        osc_tick = 1'b0;
    logic [7:0]  div_ratio = 8'd1;
    logic [7:0]  win_len = 8'd4;
    logic        rand_en = 1'b0;
    logic        seed_valid = 1'b0;
    logic [15:0] seed = 16'h0;
    logic        eng_clk_en;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    rand_clk_skipper u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .src_sel    (src_sel),
        .pll_tick   (pll_tick),
        .osc_tick   (osc_tick),
        .div_ratio  (div_ratio),
        .win_len    (win_len),
        .rand_en    (rand_en),
        .seed_valid (seed_valid),
        .seed       (seed),
        .eng_clk_en (eng_clk_en)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // Stepping rule from R6
    function automatic logic [15:0] ref_step(input logic [15:0] v);
        return {v[14:0], v[15] ^ v[13] ^ v[12] ^ v[10]};
    endfunction

    // Reseed, then drive nticks selected ticks with gap idle cycles between them.
    // The unselected source ticks every cycle. Randomization turns on from window on_win.
    task automatic run_stream(input string tag, input logic sel, input int ratio,
                              input int win, input logic rnd, input int on_win,
                              input logic [15:0] sd, input int nticks, input int gap);
        int          w_eff;
        int          n_eff;
        int          d;
        int          tgt;
        int          in_win;
        bit          exp_en;
        bit          rnd_now;
        logic [15:0] lf;
        @(negedge clk);
        src_sel    = sel;
        div_ratio  = 8'(ratio);
        win_len    = 8'(win);
        rand_en    = 1'b0;
        pll_tick   = sel;
        osc_tick   = !sel;
        seed_valid = 1'b1;
        seed       = sd;
        @(negedge clk);
        seed_valid = 1'b0;
        chk({tag, " R7 no enable after reseed"}, int'(eng_clk_en), 0);

        w_eff  = (win < 2) ? 2 : win;
        n_eff  = (ratio < 1) ? 1 : ratio;
        lf     = (sd == 16'h0) ? 16'hACE1 : sd;   // R8
        tgt    = int'(lf % 16'(w_eff));
        d      = 0;
        in_win = 0;
        for (int i = 0; i < nticks; i++) begin
            rnd_now = rnd && ((d / w_eff) >= on_win);
            rand_en = rnd_now;
            if (sel) osc_tick = 1'b1; else pll_tick = 1'b1;
            @(negedge clk);
            if (sel) osc_tick = 1'b0; else pll_tick = 1'b0;
            exp_en = 1'b0;
            if (((i + 1) % n_eff) == 0) begin
                exp_en = !(rnd_now && ((d % w_eff) == tgt));
                in_win += int'(eng_clk_en);
                if ((d % w_eff) == w_eff - 1) begin
                    chk({tag, " R5 enables per window"}, in_win,
                        rnd_now ? w_eff - 1 : w_eff);
                    in_win = 0;
                    lf  = ref_step(lf);                 // R6
                    tgt = int'(lf % 16'(w_eff));
                end
                d++;
            end
            chk({tag, " R3/R5/R6 enable stream"}, int'(eng_clk_en), int'(exp_en));
            for (int g = 0; g < gap; g++) begin
                @(negedge clk);
                chk({tag, " R2 unselected source ignored"}, int'(eng_clk_en), 0);
            end
        end
        pll_tick = 1'b0;
        osc_tick = 1'b0;
        rand_en  = 1'b0;
    endtask

    task automatic t_reset;
        rst_n    = 1'b0;
        rand_en  = 1'b1;
        pll_tick = 1'b1;
        repeat (3) @(negedge clk);
        chk("R1 enable low in reset", int'(eng_clk_en), 0);
        pll_tick = 1'b0;
        rst_n    = 1'b1;
        repeat (3) @(negedge clk);
        chk("R1 enable low with no ticks", int'(eng_clk_en), 0);
        rand_en = 1'b0;
    endtask

    task automatic t_basic;
        run_stream("basic", 1'b0, 1, 4, 1'b1, 0, 16'h1234, 40, 0);
    endtask

    task automatic t_osc_divided;
        run_stream("osc_div3", 1'b1, 3, 5, 1'b1, 0, 16'hBEEF, 60, 1);
    endtask

    task automatic t_zero_seed;
        run_stream("zero_seed R8", 1'b0, 1, 7, 1'b1, 0, 16'h0000, 42, 0);
    endtask

    task automatic t_disabled;
        run_stream("rand_off R9", 1'b1, 2, 3, 1'b0, 0, 16'h5A5A, 30, 0);
    endtask

    task automatic t_late_enable;
        run_stream("late_on R9", 1'b0, 1, 3, 1'b1, 3, 16'h0F0F, 30, 0);
    endtask

    task automatic t_bounds;
        run_stream("clamp R4", 1'b0, 0, 0, 1'b1, 0, 16'h0003, 20, 0);
        run_stream("win1 R4", 1'b1, 1, 1, 1'b1, 0, 16'h8001, 16, 1);
    endtask

    task automatic t_long_window;
        run_stream("win37", 1'b0, 1, 37, 1'b1, 0, 16'hFFFF, 111, 0);
    endtask

    initial begin
        t_reset();
        t_basic();
        t_osc_divided();
        t_zero_seed();
        t_disabled();
        t_late_enable();
        t_bounds();
        t_long_window();
        if (!finished) begin
            finished = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        #500000;
        if (!finished) begin
            finished = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=running expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

endmodule